// File: doc/BRIEF.md
# UART Baud Tick Generator with Receive Resynchronisation

This block produces the bit-rate timing for a serial transmitter and receiver. An 8-bit up-counter is advanced by a step pulse taken from one of six selectable prescale sources. When the counter passes its all-ones value, it reloads from a programmable 8-bit reload value. Every second overflow yields a one-cycle transmit bit tick, so one bit lasts 2 × (256 − reload) steps. For example, a 22.1184 MHz system clock with reload 0xA0 gives 192 clocks per bit, which is 115200 baud.

A second counter drives the receive side. It uses the same reload value and the same step pulses but keeps its own overflow divider. A falling edge on the synchronised receive line, seen while the receiver framer reports idle, forces this counter to reload and clears its divider. The receive bit timing therefore starts fresh at each start bit, whatever the phase of the transmit counter. All prescaled sources are clock-enable pulses in the single system clock domain. The frame logic that uses the ticks lies outside this block.

Top module: `baud_gen_top`

## Requirements
- R1: `src_sel` selects the step source. 0 steps every clock. 1 steps every 4th clock, 2 every 12th clock and 3 every 48th clock. 4 steps on every 8th `ext_clk_pulse`. 5 steps on every `ext_in_pulse`. Codes 6 and 7 never step.
- R2: On each step the transmit counter increments by one. A step taken at 0xFF reloads the counter from `reload_val`.
- R3: In steady state, `tx_tick` is a one-cycle pulse on every second overflow. Its period is therefore 2 × (256 − `reload_val`) steps.
- R4: Take source 0, with `tmr_en` raised after at least one clock with it low. The first `tx_tick` is high in the cycle after the 2 × (256 − `reload_val`)-th clock edge, and low in the cycle before it.
- R5: While `tmr_en` is low, both counters are held at `reload_val`, both dividers are cleared, and neither tick is asserted.
- R6: Without a receive start edge, the receive counter follows the same reload and step. `rx_tick` then coincides cycle for cycle with `tx_tick`.
- R7: `rx_pin` passes through a two-flop synchroniser. Suppose it falls while `tmr_en` is high and `rx_busy` is low. The receive counter then reloads and its divider clears on the third clock edge after the fall. The next `rx_tick` follows 2 × (256 − `reload_val`) steps after that edge.
- R8: A falling edge on `rx_pin` while `rx_busy` is high has no effect on the receive timing.
- R9: A receive resynchronisation leaves the phase and period of `tx_tick` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer run enable |
| src_sel | input | 3 | Step source select (codes per R1) |
| reload_val | input | 8 | Counter reload value |
| ext_clk_pulse | input | 1 | One-cycle pulse per external oscillator period (already in clk domain) |
| ext_in_pulse | input | 1 | One-cycle pulse per external count input event (already in clk domain) |
| rx_pin | input | 1 | Asynchronous serial receive line |
| rx_busy | input | 1 | High while the receive framer is inside a frame |
| tx_tick | output | 1 | Transmit bit tick, one cycle wide |
| rx_tick | output | 1 | Receive bit tick, one cycle wide |

## Verification
Every source code is paired with a reload value, and the interval between steady-state ticks is measured. This tells a wrong prescale divisor apart from a wrong reload span and from a missing divide by two. Reload values 0xFF and 0x00 exercise the shortest and longest spans. The external sources are driven at pulse rates unlike any internal divisor, so a miswired source shows up. A start edge dropped a few cycles after a transmit tick moves the receive tick away from the transmit tick by a known number of cycles. Without that edge, or with a busy receiver, the two ticks stay locked together. This separates a working resynchronisation from one that is absent or that fires when it should not.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int CNT_W    = 8;
  localparam int PRE_A    = 4;
  localparam int PRE_B    = 12;
  localparam int PRE_C    = 48;   // must be a multiple of PRE_A and PRE_B
  localparam int EXT_DIV  = 8;
  localparam int SYNC_LEN = 2;

  typedef enum logic [2:0] {
    SRC_SYS   = 3'd0,
    SRC_DIV_A = 3'd1,
    SRC_DIV_B = 3'd2,
    SRC_DIV_C = 3'd3,
    SRC_EXT8  = 3'd4,
    SRC_EXTIN = 3'd5
  } step_src_e;

  // true on the last count of a divide-by-div window inside a shared modulo counter
  function automatic logic div_hit(input int unsigned cnt, input int unsigned div);
    return (cnt % div) == (div - 1);
  endfunction

  // steps between two bit ticks for a given reload value
  function automatic int unsigned steps_per_bit(input logic [CNT_W-1:0] rld);
    return 2 * ((1 << CNT_W) - int'(rld));
  endfunction
endpackage

// File: rtl/baud_step_gen.sv
module baud_step_gen
  import baud_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] src_sel,
  input  logic       ext_clk_pulse,
  input  logic       ext_in_pulse,
  output logic       step_o
);
  localparam int DW = $clog2(PRE_C);
  localparam int EW = $clog2(EXT_DIV);

  logic [DW-1:0] div_q;
  logic [EW-1:0] ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '0;
    end else if (!run) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= (int'(div_q) == PRE_C - 1) ? '0 : div_q + 1'b1;
      if (ext_clk_pulse) ext_q <= ext_q + 1'b1;
    end
  end

  logic raw_step;
  always_comb begin
    case (src_sel)
      SRC_SYS:   raw_step = 1'b1;
      SRC_DIV_A: raw_step = div_hit(int'(div_q), PRE_A);
      SRC_DIV_B: raw_step = div_hit(int'(div_q), PRE_B);
      SRC_DIV_C: raw_step = div_hit(int'(div_q), PRE_C);
      SRC_EXT8:  raw_step = ext_clk_pulse && (int'(ext_q) == EXT_DIV - 1);
      SRC_EXTIN: raw_step = ext_in_pulse;
      default:   raw_step = 1'b0;
    endcase
  end

  assign step_o = run && raw_step;
endmodule

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr
  import baud_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             force_load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic             tick_q;

  assign ovf_o = run && !force_load && step && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (!run || force_load) begin
        cnt_q  <= reload;
        half_q <= 1'b0;
      end else if (step) begin
        if (cnt_q == '1) begin
          cnt_q  <= reload;
          half_q <= ~half_q;
          tick_q <= half_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/baud_start_detect.sv
module baud_start_detect
  import baud_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rx_pin,
  input  logic rx_busy,
  output logic start_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic                last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], rx_pin};
      last_q <= sync_q[SYNC_LEN-1];
    end
  end

  assign start_o = run && !rx_busy && last_q && !sync_q[SYNC_LEN-1];
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_en,
  input  logic [2:0] src_sel,
  input  logic [7:0] reload_val,
  input  logic       ext_clk_pulse,
  input  logic       ext_in_pulse,
  input  logic       rx_pin,
  input  logic       rx_busy,
  output logic       tx_tick,
  output logic       rx_tick
);
  logic             step;
  logic             rx_force;
  logic [CNT_W-1:0] tx_cnt;
  logic [CNT_W-1:0] rx_cnt;
  logic             tx_ovf;
  logic             rx_ovf;

  baud_step_gen u_step (
    .clk(clk), .rst_n(rst_n), .run(tmr_en), .src_sel(src_sel),
    .ext_clk_pulse(ext_clk_pulse), .ext_in_pulse(ext_in_pulse), .step_o(step)
  );

  baud_start_detect u_start (
    .clk(clk), .rst_n(rst_n), .run(tmr_en), .rx_pin(rx_pin),
    .rx_busy(rx_busy), .start_o(rx_force)
  );

  baud_reload_ctr u_tx_ctr (
    .clk(clk), .rst_n(rst_n), .run(tmr_en), .step(step), .force_load(1'b0),
    .reload(reload_val), .cnt_o(tx_cnt), .ovf_o(tx_ovf), .tick_o(tx_tick)
  );

  baud_reload_ctr u_rx_ctr (
    .clk(clk), .rst_n(rst_n), .run(tmr_en), .step(step), .force_load(rx_force),
    .reload(reload_val), .cnt_o(rx_cnt), .ovf_o(rx_ovf), .tick_o(rx_tick)
  );
endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_en,
  input logic [7:0] reload_val,
  input logic       tx_tick,
  input logic       rx_tick,
  input logic       tx_ovf,
  input logic       rx_force,
  input logic [7:0] tx_cnt,
  input logic [7:0] rx_cnt
);
  a_r2_reload_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_cnt == $past(reload_val));

  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);

  a_r3_rx_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> !rx_tick);

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> (!tx_tick && !rx_tick));

  a_r6_counters_match_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> rx_cnt == tx_cnt);

  a_r7_resync_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rx_force |=> (rx_cnt == $past(reload_val) && !rx_tick));
endmodule

bind baud_gen_top baud_gen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .reload_val(reload_val),
  .tx_tick(tx_tick), .rx_tick(rx_tick), .tx_ovf(tx_ovf), .rx_force(rx_force),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/baud_gen_top_tb_top.sv
module baud_gen_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_en = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [7:0] reload_val = 8'h00;
  logic       ext_clk_pulse = 1'b0;
  logic       ext_in_pulse = 1'b0;
  logic       rx_pin = 1'b1;
  logic       rx_busy = 1'b0;
  logic       tx_tick;
  logic       rx_tick;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_gen_top dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .src_sel(src_sel),
    .reload_val(reload_val), .ext_clk_pulse(ext_clk_pulse),
    .ext_in_pulse(ext_in_pulse), .rx_pin(rx_pin), .rx_busy(rx_busy),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  // external oscillator pulse every 3 clocks, external input pulse every 5 clocks
  initial forever begin
    repeat (2) @(negedge clk);
    ext_clk_pulse = 1'b1;
    @(negedge clk);
    ext_clk_pulse = 1'b0;
  end
  initial forever begin
    repeat (4) @(negedge clk);
    ext_in_pulse = 1'b1;
    @(negedge clk);
    ext_in_pulse = 1'b0;
  end

  // {src, reload, expected tick period in clocks}
  localparam logic [26:0] VEC [8] = '{
    {3'd0, 8'hA0, 16'd192},
    {3'd1, 8'hF0, 16'd128},
    {3'd2, 8'hF8, 16'd192},
    {3'd3, 8'hFC, 16'd384},
    {3'd0, 8'hFF, 16'd2},
    {3'd0, 8'h00, 16'd512},
    {3'd4, 8'hFE, 16'd96},
    {3'd5, 8'hFD, 16'd30}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] s, input logic [7:0] r);
    @(negedge clk);
    tmr_en = 1'b0;
    src_sel = s;
    reload_val = r;
    repeat (2) @(negedge clk);
    tmr_en = 1'b1;
  endtask

  // wait for a tx tick at negedge, returns clocks waited (0 on timeout)
  task automatic wait_tick(input bit chk_align, output int n, output int mis);
    n = 0;
    mis = 0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (chk_align && (rx_tick !== tx_tick)) mis++;
      if (tx_tick) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic measure(input string req, input int exp, input bit chk_align);
    int n, mis, m2;
    wait_tick(chk_align, n, mis);
    wait_tick(chk_align, n, m2);
    mis += m2;
    wait_tick(chk_align, n, m2);
    mis += m2;
    check(req, n, exp);
    if (chk_align) check({req, " R6 rx aligned"}, mis, 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    int n, mis;
    repeat (3) @(negedge clk);
    check("R5 reset tx_tick", int'(tx_tick), 0);
    check("R5 reset rx_tick", int'(rx_tick), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R6: table walk
    foreach (VEC[k]) begin
      restart(VEC[k][26:24], VEC[k][23:16]);
      measure($sformatf("R1 R3 vec%0d period", k), int'(VEC[k][15:0]), 1'b1);
    end

    // R4: first tick after enable, source 0, reload 0xF0 -> 32 edges
    restart(3'd0, 8'hF0);
    repeat (31) @(posedge clk);
    @(negedge clk);
    check("R4 no tick before 32nd edge", int'(tx_tick), 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 tick after 32nd edge", int'(tx_tick), 1);
    check("R6 rx tick with tx at start", int'(rx_tick), 1);

    // R7 R9: resync 5 clocks after a tx tick
    wait_tick(1'b0, n, mis);
    repeat (5) @(negedge clk);
    rx_pin = 1'b0;
    cnt = 0;
    repeat (34) begin
      @(negedge clk);
      cnt += int'(rx_tick);
    end
    check("R7 no rx tick before resync span", cnt, 0);
    @(negedge clk);
    check("R7 rx tick 32 edges after reload", int'(rx_tick), 1);
    check("R9 tx tick not moved", int'(tx_tick), 0);
    rx_pin = 1'b1;
    measure("R9 tx period after resync", 32, 1'b0);

    // R8: falling edge while busy is ignored
    rx_busy = 1'b1;
    restart(3'd0, 8'hF0);
    repeat (10) @(negedge clk);
    rx_pin = 1'b0;
    measure("R8 busy edge ignored", 32, 1'b1);
    rx_pin = 1'b1;
    rx_busy = 1'b0;

    // R1: unused source code never steps
    restart(3'd6, 8'hFF);
    cnt = 0;
    repeat (600) begin
      @(negedge clk);
      cnt += int'(tx_tick) + int'(rx_tick);
    end
    check("R1 code 6 no ticks", cnt, 0);

    // R5: disabled timer gives no ticks
    @(negedge clk);
    src_sel = 3'd0;
    tmr_en = 1'b0;
    cnt = 0;
    repeat (600) begin
      @(negedge clk);
      cnt += int'(tx_tick) + int'(rx_tick);
    end
    check("R5 disabled no ticks", cnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule